// File: doc/BRIEF.md
# High-Voltage Programming Entry Sequencer

This block sits on the host side of a device programmer. It steps a target chip into its high-voltage serial programming mode and later drops it out again. It drives these lines:

- the target supply enable;
- a low drive for the target's reset pin;
- the enable for the 12 V reset switch;
- a serial clock line;
- three mode-select lines.

Mode-select lines 0 and 1 share one output enable. Line 2 has its own output enable, because the target starts sending data on that pin once it has latched the mode. The analog switches and the later instruction shifting are handled elsewhere.

A one-cycle `start_i` pulse launches entry. The normal path holds reset low with supply on and gives a burst of complete clock cycles. It then drives the mode lines to 000 and waits a setup time. Next it switches 12 V onto reset, holds the mode lines for a latch time, and releases line 2. After a settling time counted from the 12 V edge, it raises `ready_o`. The alternate path is for targets whose reset pin or clock source cannot be used. It sends no clock: it drives the mode lines to 000, waits the same setup time, then enables supply and 12 V in the same cycle. `exit_i` powers the target down from any state.

Every interval is given in nanoseconds and converted to clock cycles at elaboration. The conversion rounds up, so no minimum time can be cut short.

Top module: `hv_prog_entry`

## Requirements
- R1: Out of reset and in idle, every output is 0: supply, reset-low drive, 12 V enable, serial clock, both mode-select enables, ready. The mode-select value `msel_o` is always 000.
- R2: On the normal path, the cycle after `start_i` is sampled, supply and the reset-low drive turn on. The serial clock then makes exactly SCLK_CYCLES complete low-high-low cycles. Each level lasts SCLK_HALF_CYC clocks, and the first rise comes SCLK_HALF_CYC clocks after supply turns on. The mode-select enables turn on only after the last falling edge.
- R3: Both mode-select enables are on for exactly N_SETUP cycles before the 12 V enable rises. On the normal path, the reset-low drive turns off in the same cycle that the 12 V enable rises.
- R4: Mode-select line 2's enable turns off exactly N_HOLD cycles after the 12 V enable rises. The enable of lines 0 and 1 stays on.
- R5: `ready_o` rises exactly N_SETTLE cycles after the 12 V enable rises, or N_HOLD+1 cycles after it if N_SETTLE is not larger than N_HOLD. It then stays high until exit.
- R6: On the alternate path (`alt_path_i`=1 when start is sampled), the serial clock never toggles and the reset-low drive stays off. The mode-select enables turn on the cycle after start. Supply and the 12 V enable rise in the same cycle, N_SETUP cycles later.
- R7: `exit_i` sampled high in any state makes every output 0 in the next cycle. It wins over a `start_i` seen in the same cycle.
- R8: `start_i` is ignored while a sequence is running or ready, and so is `alt_path_i` at that time.
- R9: N_SETUP, N_HOLD and N_SETTLE each equal ceil(ns × 1000 / CLK_PERIOD_PS), with a floor of 1 cycle.
- R10: The 12 V enable and the reset-low drive are never on in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Pulse that launches entry from idle |
| alt_path_i | input | 1 | Selects the alternate path when start is taken |
| exit_i | input | 1 | Leave programming mode and power the target down |
| supply_en_o | output | 1 | Target supply switch enable |
| rst_low_o | output | 1 | Drive the target reset pin to 0 |
| hv_en_o | output | 1 | Switch 12 V onto the target reset pin |
| sclk_o | output | 1 | Serial clock to the target |
| msel_o | output | 3 | Mode-select value (always 000) |
| msel_lo_oe_o | output | 1 | Output enable of mode-select lines 0 and 1 |
| msel2_oe_o | output | 1 | Output enable of mode-select line 2 |
| ready_o | output | 1 | Serial instructions may begin |

## Verification
The bench uses CLK_PERIOD_PS=5000 and SCLK_HALF_CYC=2. It sets SETUP_NS=101, HOLD_NS=100 and SETTLE_NS=2003. With these values the setup and settling conversions land on a fraction (21 and 401 cycles), while the hold lands exactly on 20, so both sides of the round-up are observed. Shortening the settling time from 50 µs to about 2 µs keeps both full paths, the aborts in each state and the ignored restarts inside a few thousand cycles. A half period of two clocks makes the counted clock burst longer than one clock per level, so a miscounted edge or cycle shows in the measured edge spacing.

// File: rtl/hvp_pkg.sv
// Package: shared state type and the time-to-cycle conversion of the entry sequencer.
// Assumes: the clock period is given in picoseconds and intervals in nanoseconds.
package hvp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLOCK,
        ST_SETUP,
        ST_HOLD,
        ST_SETTLE,
        ST_READY
    } seq_state_e;

    // Round a time in ns up to whole clock cycles, never less than one cycle.
    function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                                 input int unsigned period_ps);
        int unsigned n;
        n = (ns * 1000 + period_ps - 1) / period_ps;
        return (n == 0) ? 1 : n;
    endfunction

endpackage

// File: rtl/hvp_interval_timer.sv
// Module: down-counter shared by all timed phases.
// Loading N-1 on phase entry gives a phase of exactly N cycles.
// Assumes: the load value fits in W bits; expired_o is high while the count is 0.
module hvp_interval_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         expired_o
);

    logic [W-1:0] cnt_q;

    // Load a new interval or count the current one down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/hvp_clock_toggler.sv
// Module: serial clock burst generator.
// While enabled it gives CYCLES complete low-high-low cycles, each level lasting
// HALF_CYC system clocks, and then holds the line low with done_o set.
// Assumes: HALF_CYC >= 1, CYCLES >= 1; dropping en_i clears it on the next edge.
module hvp_clock_toggler #(
    parameter int unsigned HALF_CYC = 1,
    parameter int unsigned CYCLES   = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic sclk_o,
    output logic done_o
);

    localparam int unsigned HW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam int unsigned CW = $clog2(CYCLES + 1);
    localparam logic [HW-1:0] HALF_LAST = HW'(HALF_CYC - 1);
    localparam logic [CW-1:0] CYC_ALL   = CW'(CYCLES);

    logic [HW-1:0] half_q;
    logic [CW-1:0] cyc_q;
    logic          sclk_q;

    // Time each level and count the falling edges that finish a cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            half_q <= '0;
            cyc_q  <= '0;
            sclk_q <= 1'b0;
        end else if (cyc_q != CYC_ALL) begin
            if (half_q == HALF_LAST) begin
                half_q <= '0;
                sclk_q <= ~sclk_q;
                if (sclk_q) begin
                    cyc_q <= cyc_q + 1'b1;
                end
            end else begin
                half_q <= half_q + 1'b1;
            end
        end
    end

    assign sclk_o = sclk_q;
    assign done_o = (cyc_q == CYC_ALL);

endmodule

// File: rtl/hvp_seq_ctrl.sv
// Module: phase controller of the entry sequencer.
// It picks the path, steps through the phases, loads the timer and decodes the pin
// controls from the state register. Exit takes priority over every other input.
// Assumes: the timer expires N cycles after a load of N-1; tog_done_i comes from the toggler.
module hvp_seq_ctrl
    import hvp_pkg::*;
#(
    parameter int unsigned TW      = 8,
    parameter int unsigned N_SETUP = 1,
    parameter int unsigned N_HOLD  = 1,
    parameter int unsigned N_SS    = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          alt_path_i,
    input  logic          exit_i,
    input  logic          tmr_expired_i,
    input  logic          tog_done_i,
    output logic          tmr_load_o,
    output logic [TW-1:0] tmr_val_o,
    output logic          tog_en_o,
    output logic          supply_en_o,
    output logic          rst_low_o,
    output logic          hv_en_o,
    output logic          msel_lo_oe_o,
    output logic          msel2_oe_o,
    output logic          ready_o
);

    seq_state_e state_q, state_d;
    logic       alt_q, alt_d;

    // Choose the next phase and the interval the timer gets on entering it.
    always_comb begin
        state_d    = state_q;
        alt_d      = alt_q;
        tmr_load_o = 1'b0;
        tmr_val_o  = '0;
        if (exit_i) begin
            state_d = ST_IDLE;
            alt_d   = 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    alt_d = alt_path_i;
                    if (alt_path_i) begin
                        state_d    = ST_SETUP;
                        tmr_load_o = 1'b1;
                        tmr_val_o  = TW'(N_SETUP - 1);
                    end else begin
                        state_d = ST_CLOCK;
                    end
                end
                ST_CLOCK: if (tog_done_i) begin
                    state_d    = ST_SETUP;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = TW'(N_SETUP - 1);
                end
                ST_SETUP: if (tmr_expired_i) begin
                    state_d    = ST_HOLD;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = TW'(N_HOLD - 1);
                end
                ST_HOLD: if (tmr_expired_i) begin
                    state_d    = ST_SETTLE;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = TW'(N_SS - 1);
                end
                ST_SETTLE: if (tmr_expired_i) begin
                    state_d = ST_READY;
                end
                default: state_d = state_q;
            endcase
        end
    end

    // Hold the phase and the path chosen at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            alt_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            alt_q   <= alt_d;
        end
    end

    // Decode the pin controls from the phase register only.
    always_comb begin
        supply_en_o  = (state_q == ST_CLOCK) || ((state_q == ST_SETUP) && !alt_q) ||
                       (state_q == ST_HOLD) || (state_q == ST_SETTLE) || (state_q == ST_READY);
        rst_low_o    = (state_q == ST_CLOCK) || ((state_q == ST_SETUP) && !alt_q);
        hv_en_o      = (state_q == ST_HOLD) || (state_q == ST_SETTLE) || (state_q == ST_READY);
        msel_lo_oe_o = (state_q == ST_SETUP) || hv_en_o;
        msel2_oe_o   = (state_q == ST_SETUP) || (state_q == ST_HOLD);
        ready_o      = (state_q == ST_READY);
        tog_en_o     = (state_q == ST_CLOCK) && !exit_i;
    end

endmodule

// File: rtl/hv_prog_entry.sv
// Module: top of the entry sequencer.
// It turns the nanosecond parameters into cycle counts, rounding up, and wires the
// phase controller to the shared timer and the clock toggler.
// Assumes: CLK_PERIOD_PS is the real period of clk; the analog switches follow the enables.
module hv_prog_entry
    import hvp_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_PS = 5000,
    parameter int unsigned SCLK_HALF_CYC = 1,
    parameter int unsigned SCLK_CYCLES   = 6,
    parameter int unsigned SETUP_NS      = 100,
    parameter int unsigned HOLD_NS       = 100,
    parameter int unsigned SETTLE_NS     = 50000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       alt_path_i,
    input  logic       exit_i,
    output logic       supply_en_o,
    output logic       rst_low_o,
    output logic       hv_en_o,
    output logic       sclk_o,
    output logic [2:0] msel_o,
    output logic       msel_lo_oe_o,
    output logic       msel2_oe_o,
    output logic       ready_o
);

    localparam int unsigned N_SETUP  = ns_to_cycles(SETUP_NS, CLK_PERIOD_PS);
    localparam int unsigned N_HOLD   = ns_to_cycles(HOLD_NS, CLK_PERIOD_PS);
    localparam int unsigned N_SETTLE = ns_to_cycles(SETTLE_NS, CLK_PERIOD_PS);
    localparam int unsigned N_SS     = (N_SETTLE > N_HOLD) ? (N_SETTLE - N_HOLD) : 1;
    localparam int unsigned N_MAX_A  = (N_SETUP > N_HOLD) ? N_SETUP : N_HOLD;
    localparam int unsigned N_MAX    = (N_MAX_A > N_SS) ? N_MAX_A : N_SS;
    localparam int unsigned TW       = $clog2(N_MAX + 1);

    logic          tmr_load, tmr_expired, tog_en, tog_done;
    logic [TW-1:0] tmr_val;

    hvp_seq_ctrl #(
        .TW      (TW),
        .N_SETUP (N_SETUP),
        .N_HOLD  (N_HOLD),
        .N_SS    (N_SS)
    ) i_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .alt_path_i    (alt_path_i),
        .exit_i        (exit_i),
        .tmr_expired_i (tmr_expired),
        .tog_done_i    (tog_done),
        .tmr_load_o    (tmr_load),
        .tmr_val_o     (tmr_val),
        .tog_en_o      (tog_en),
        .supply_en_o   (supply_en_o),
        .rst_low_o     (rst_low_o),
        .hv_en_o       (hv_en_o),
        .msel_lo_oe_o  (msel_lo_oe_o),
        .msel2_oe_o    (msel2_oe_o),
        .ready_o       (ready_o)
    );

    hvp_interval_timer #(.W(TW)) i_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_expired)
    );

    hvp_clock_toggler #(
        .HALF_CYC (SCLK_HALF_CYC),
        .CYCLES   (SCLK_CYCLES)
    ) i_toggler (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (tog_en),
        .sclk_o (sclk_o),
        .done_o (tog_done)
    );

    // The mode pattern is all zeros; only the enables change.
    assign msel_o = 3'b000;

endmodule

// File: rtl/hvp_checker.sv
// Module: timing and safety properties of the entry sequencer, attached by bind.
// Assumes: the same time parameters as the top; counters track how long the
// mode enables and the 12 V enable have been on.
module hvp_checker
    import hvp_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_PS = 5000,
    parameter int unsigned SETUP_NS      = 100,
    parameter int unsigned HOLD_NS       = 100,
    parameter int unsigned SETTLE_NS     = 50000
) (
    input logic clk,
    input logic rst_n,
    input logic exit_i,
    input logic supply_en_o,
    input logic rst_low_o,
    input logic hv_en_o,
    input logic sclk_o,
    input logic msel_lo_oe_o,
    input logic msel2_oe_o,
    input logic ready_o
);

    localparam int unsigned N_SETUP  = ns_to_cycles(SETUP_NS, CLK_PERIOD_PS);
    localparam int unsigned N_HOLD   = ns_to_cycles(HOLD_NS, CLK_PERIOD_PS);
    localparam int unsigned N_SETTLE = ns_to_cycles(SETTLE_NS, CLK_PERIOD_PS);

    int unsigned hv_run, msel_run;

    // Count the cycles the 12 V enable and the mode enables have been on, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hv_run   <= 0;
            msel_run <= 0;
        end else begin
            hv_run   <= !hv_en_o ? 0 : ((hv_run == 32'hFFFF_FFFF) ? hv_run : hv_run + 1);
            msel_run <= !msel_lo_oe_o ? 0 : ((msel_run == 32'hFFFF_FFFF) ? msel_run : msel_run + 1);
        end
    end

    a_r10_hv_excl_rst: assert property (@(posedge clk) disable iff (!rst_n)
        hv_en_o |-> !rst_low_o);

    a_r7_exit_safe: assert property (@(posedge clk) disable iff (!rst_n)
        exit_i |=> (!supply_en_o && !rst_low_o && !hv_en_o && !sclk_o &&
                    !msel_lo_oe_o && !msel2_oe_o && !ready_o));

    a_r3_setup_time: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hv_en_o) |-> (msel_lo_oe_o && msel2_oe_o && msel_run >= N_SETUP));

    a_r4_hold_time: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(msel2_oe_o) && hv_en_o) |-> (hv_run >= N_HOLD && msel_lo_oe_o));

    a_r5_settle_time: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> (hv_en_o && !msel2_oe_o && hv_run >= N_SETTLE));

    a_r2_clock_context: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> (supply_en_o && rst_low_o && !msel_lo_oe_o));

    a_r6_alt_together: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(supply_en_o) && !rst_low_o) |-> hv_en_o);

endmodule

bind hv_prog_entry hvp_checker #(
    .CLK_PERIOD_PS (CLK_PERIOD_PS),
    .SETUP_NS      (SETUP_NS),
    .HOLD_NS       (HOLD_NS),
    .SETTLE_NS     (SETTLE_NS)
) i_hvp_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .exit_i       (exit_i),
    .supply_en_o  (supply_en_o),
    .rst_low_o    (rst_low_o),
    .hv_en_o      (hv_en_o),
    .sclk_o       (sclk_o),
    .msel_lo_oe_o (msel_lo_oe_o),
    .msel2_oe_o   (msel2_oe_o),
    .ready_o      (ready_o)
);

// File: tb/test_hv_prog_entry.sv
`timescale 1ns/1ps
// Bench: a vector table of path/abort cases walked by one loop, then directed
// checks of reset, ignored starts and exit priority.
module test_hv_prog_entry;

    localparam int unsigned PER_PS = 5000;
    localparam int unsigned HALF   = 2;
    localparam int unsigned NCYC   = 6;
    // Expected counts from R9: ceil(101000/5000)=21, 100000/5000=20, ceil(2003000/5000)=401
    localparam int EXP_SETUP  = 21;
    localparam int EXP_HOLD   = 20;
    localparam int EXP_SETTLE = 401;

    logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, alt_path_i = 1'b0, exit_i = 1'b0;
    logic supply_en_o, rst_low_o, hv_en_o, sclk_o, msel_lo_oe_o, msel2_oe_o, ready_o;
    logic [2:0] msel_o;

    hv_prog_entry #(
        .CLK_PERIOD_PS (PER_PS),
        .SCLK_HALF_CYC (HALF),
        .SCLK_CYCLES   (NCYC),
        .SETUP_NS      (101),
        .HOLD_NS       (100),
        .SETTLE_NS     (2003)
    ) i_hv_prog_entry (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .alt_path_i(alt_path_i),
        .exit_i(exit_i), .supply_en_o(supply_en_o), .rst_low_o(rst_low_o),
        .hv_en_o(hv_en_o), .sclk_o(sclk_o), .msel_o(msel_o),
        .msel_lo_oe_o(msel_lo_oe_o), .msel2_oe_o(msel2_oe_o), .ready_o(ready_o)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int outs();
        return {supply_en_o, rst_low_o, hv_en_o, sclk_o, msel_lo_oe_o, msel2_oe_o, ready_o, msel_o};
    endfunction

    // Edge recorder, sampled on the falling clock edge.
    int t_sup, t_hv, t_msel, t_m2off, t_rdy, t_rloff, t_s1, t_s2, t_lastfall, n_rise;
    logic p_sup, p_hv, p_msel, p_m2, p_rdy, p_rl, p_sclk;

    task automatic clear_rec();
        t_sup = -1; t_hv = -1; t_msel = -1; t_m2off = -1; t_rdy = -1; t_rloff = -1;
        t_s1 = -1; t_s2 = -1; t_lastfall = -1; n_rise = 0;
        p_sup = supply_en_o; p_hv = hv_en_o; p_msel = msel_lo_oe_o; p_m2 = msel2_oe_o;
        p_rdy = ready_o; p_rl = rst_low_o; p_sclk = sclk_o;
    endtask

    always @(negedge clk) begin
        if (supply_en_o && !p_sup && t_sup < 0) t_sup = cyc;
        if (hv_en_o && !p_hv && t_hv < 0) t_hv = cyc;
        if (msel_lo_oe_o && !p_msel && t_msel < 0) t_msel = cyc;
        if (!msel2_oe_o && p_m2 && t_m2off < 0) t_m2off = cyc;
        if (ready_o && !p_rdy && t_rdy < 0) t_rdy = cyc;
        if (!rst_low_o && p_rl && t_rloff < 0) t_rloff = cyc;
        if (sclk_o && !p_sclk) begin
            n_rise++;
            if (n_rise == 1) t_s1 = cyc;
            if (n_rise == 2) t_s2 = cyc;
        end
        if (!sclk_o && p_sclk) t_lastfall = cyc;
        p_sup = supply_en_o; p_hv = hv_en_o; p_msel = msel_lo_oe_o; p_m2 = msel2_oe_o;
        p_rdy = ready_o; p_rl = rst_low_o; p_sclk = sclk_o;
    end

    task automatic pulse_start(input logic alt);
        @(negedge clk); start_i = 1'b1; alt_path_i = alt;
        @(negedge clk); start_i = 1'b0; alt_path_i = 1'b0;
    endtask

    task automatic do_exit_check(input string tag);
        exit_i = 1'b1;
        @(negedge clk); exit_i = 1'b0;
        chk({tag, " R7 outputs safe after exit"}, outs(), 0);
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 3000 && !ready_o; i++) @(negedge clk);
    endtask

    task automatic check_full(input logic alt);
        if (!alt) begin
            chk("R2 sclk rise count", n_rise, NCYC);
            chk("R2 first rise after supply", t_s1 - t_sup, HALF);
            chk("R2 rise spacing", t_s2 - t_s1, 2 * HALF);
            chk("R2 msel after last fall", int'(t_msel > t_lastfall), 1);
            chk("R3 reset-low off with 12V", t_rloff, t_hv);
        end else begin
            chk("R6 no sclk on alternate path", n_rise, 0);
            chk("R6 supply with 12V", t_sup, t_hv);
            chk("R6 reset-low never on", t_rloff, -1);
        end
        chk("R3 R9 setup cycles", t_hv - t_msel, EXP_SETUP);
        chk("R4 R9 hold cycles", t_m2off - t_hv, EXP_HOLD);
        chk("R5 R9 settle cycles", t_rdy - t_hv, EXP_SETTLE);
        chk("R4 lines 0/1 still driven", int'(msel_lo_oe_o), 1);
    endtask

    // Vector table: {alt path, cycles until abort (0 = run to ready)}.
    localparam logic [16:0] VEC [0:6] = '{
        {1'b0, 16'd0}, {1'b1, 16'd0}, {1'b0, 16'd5}, {1'b0, 16'd40},
        {1'b0, 16'd60}, {1'b1, 16'd30}, {1'b0, 16'd200}
    };

    logic r_alt;
    int   r_ab;

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset state", outs(), 0);
        repeat (5) @(negedge clk);
        chk("R1 idle state", outs(), 0);

        for (int v = 0; v < 7; v++) begin
            r_alt = VEC[v][16];
            r_ab  = int'(VEC[v][15:0]);
            clear_rec();
            pulse_start(r_alt);
            if (r_ab == 0) begin
                wait_ready();
                @(negedge clk);
                check_full(r_alt);
                repeat (10) @(negedge clk);
                chk("R5 ready stays high", int'(ready_o && hv_en_o), 1);
                do_exit_check("full");
            end else begin
                repeat (r_ab - 1) @(negedge clk);
                do_exit_check("abort");
            end
            repeat (3) @(negedge clk);
            chk("R1 idle after exit", outs(), 0);
        end

        // R8: restart while clocking, then start while ready, both ignored.
        clear_rec();
        pulse_start(1'b0);
        repeat (8) @(negedge clk);
        pulse_start(1'b1);
        wait_ready();
        @(negedge clk);
        chk("R8 restart ignored: sclk count", n_rise, NCYC);
        chk("R8 restart ignored: settle", t_rdy - t_hv, EXP_SETTLE);
        pulse_start(1'b1);
        repeat (2) @(negedge clk);
        chk("R8 start in ready ignored", int'(ready_o && hv_en_o && supply_en_o), 1);
        do_exit_check("ready");

        // R7: start and exit together from idle.
        @(negedge clk);
        start_i = 1'b1; exit_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; exit_i = 1'b0;
        chk("R7 exit beats start", outs(), 0);
        repeat (5) @(negedge clk);
        chk("R7 stays idle", outs(), 0);

        // R1: synchronous reset during hold returns to the safe state.
        pulse_start(1'b1);
        repeat (EXP_SETUP + 5) @(negedge clk);
        chk("R1 in hold before reset", int'(hv_en_o), 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset mid-sequence", outs(), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 idle after reset", outs(), 0);

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule